// File: doc/BRIEF.md
# Exception Control Unit

This unit holds the privileged control state of a small 32-bit processor and performs the hardware half of exception entry and return. It watches six external interrupt lines, a synchronous trap request carrying a 4-bit code, and the program counter of the instruction in flight. When an exception is taken, it redirects fetch to a fixed vector in the same cycle. At the next clock edge it commits four changes: it records the cause, saves the PC, enters kernel mode and masks further interrupts.

The mode and interrupt-enable state lives in a three-entry stack of (mode, enable) pairs inside the Status register. Every exception pushes a (kernel, disabled) pair onto the stack. Every exception return pops it and sends fetch back to the saved PC. Software reaches the Status, Cause and saved-PC registers through a move-to/move-from port addressed by a 5-bit register number. Writes are honoured only in kernel mode.

Top module: `exc_ctrl`

## Requirements
- R1: After reset the unit is in kernel mode with interrupts disabled. Status (12), Cause (13) and saved PC (14) all read 0.
- R2: Taking an exception raises `redirect_o` in the same cycle with target 0x80000080. At the next edge the saved PC becomes `pc_i`, the unit enters kernel mode with interrupts disabled, and Status[5:0] shifts left by two bits with zeros filling in.
- R3: Cause layout: exception code in [5:2], software pending in [9:8], hardware pending in [15:10]. Hardware pending bits are read-only and equal `irq_i` as sampled at the previous edge.
- R4: Status layout: bit 0 current enable, bit 1 current mode (1 = user, 0 = kernel), [3:2] previous pair, [5:4] oldest pair, and interrupt mask [15:8]. Mask bit 8+i gates Cause bit 8+i. Only [15:8] and [5:0] are writable.
- R5: An interrupt is taken only when a pending bit, its mask bit and the current enable bit are all 1. When taken, it records code 0.
- R6: A trap request is taken whatever the enable bit, and records `trap_code_i` as its code.
- R7: An exception return without a simultaneous exception redirects to the saved PC. It copies previous to current and oldest to previous, and leaves the oldest pair unchanged.
- R8: Registers 12, 13 and 14 are readable in any mode. Every other register number reads 0 and ignores writes.
- R9: A move-to issued in user mode changes no register. Instead it takes an exception with code 11.
- R10: A trap in the same cycle as a pending interrupt is taken as the trap. An exception in the same cycle as an exception return wins, and the return has no effect.
- R11: The software pending bits Cause[9:8] are writable in kernel mode, and once set and enabled they cause an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 6 | External interrupt request lines |
| trap_req_i | input | 1 | Synchronous trap from the current instruction |
| trap_code_i | input | 4 | Exception code of the trap |
| pc_i | input | 32 | PC of the current instruction |
| eret_i | input | 1 | Exception-return strobe |
| reg_wr_i | input | 1 | Move-to strobe |
| reg_addr_i | input | 5 | Control register number |
| reg_wdata_i | input | 32 | Move-to data |
| reg_rdata_o | output | 32 | Move-from data (combinational) |
| redirect_o | output | 1 | Fetch redirect valid |
| redirect_pc_o | output | 32 | Fetch redirect target |
| kernel_o | output | 1 | Current mode is kernel |
| ie_o | output | 1 | Current global interrupt enable |

## Verification
The bench builds the unit with its default parameters: the vector 0x80000080 and the privilege-fault code 11. Using the fixed vector lets the scoreboard tell an entry apart from a return by target alone. Code 11 sits above every trap code the bench drives, so a privilege fault can never be confused with a trap in the recorded code. Together these make stack push/pop sequences through all three pairs, trap-versus-interrupt and exception-versus-return collisions, and user-mode write faults directly observable at the ports.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int REG_STATUS = 12;
  localparam int REG_CAUSE  = 13;
  localparam int REG_EPC    = 14;
  localparam int CODE_LSB   = 2;
  localparam int CODE_W     = 4;
  localparam int SW_LSB     = 8;
  localparam int SW_W       = 2;
  localparam int HW_LSB     = SW_LSB + SW_W;
  localparam int HW_W       = 6;
  localparam int PEND_W     = SW_W + HW_W;
  localparam int MASK_LSB   = 8;
  localparam logic [31:0] STATUS_WMASK = 32'h0000_FF3F;
  localparam logic [31:0] CAUSE_WMASK  = 32'h0000_0300;

  typedef struct packed {
    logic ku;  // 1 = user
    logic ie;
  } mode_pair_t;

  typedef mode_pair_t [2:0] mode_stack_t;  // [0] current, [1] previous, [2] oldest

  function automatic mode_stack_t stack_push(mode_stack_t s);
    mode_pair_t kern;
    kern.ku = 1'b0;
    kern.ie = 1'b0;
    return {s[1], s[0], kern};
  endfunction

  function automatic mode_stack_t stack_pop(mode_stack_t s);
    return {s[2], s[2], s[1]};
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old_v, logic [31:0] new_v,
                                        logic [31:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  function automatic logic irq_hit(logic [PEND_W-1:0] pend, logic [PEND_W-1:0] mask,
                                   logic ie);
    return ie && (|(pend & mask));
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter logic [CODE_W-1:0] PRIV_CODE = 4'd11
) (
  input  logic              trap_req_i,
  input  logic [CODE_W-1:0] trap_code_i,
  input  logic              priv_fault_i,
  input  logic              ie_i,
  input  logic [PEND_W-1:0] pend_i,
  input  logic [PEND_W-1:0] mask_i,
  output logic              take_o,
  output logic              take_trap_o,
  output logic              take_irq_o,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    take_trap_o = trap_req_i || priv_fault_i;
    take_irq_o  = !take_trap_o && irq_hit(pend_i, mask_i, ie_i);
    take_o      = take_trap_o || take_irq_o;
    if (trap_req_i)        code_o = trap_code_i;
    else if (priv_fault_i) code_o = PRIV_CODE;
    else                   code_o = '0;
  end
endmodule

// File: rtl/exc_status.sv
module exc_status
  import exc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take_i,
  input  logic        eret_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] status_o
);
  logic [31:0] status_q;
  mode_stack_t stk;

  assign stk = mode_stack_t'(status_q[5:0]);

  always_ff @(posedge clk) begin
    if (!rst_n)       status_q <= '0;
    else if (take_i)  status_q[5:0] <= stack_push(stk);
    else if (eret_i)  status_q[5:0] <= stack_pop(stk);
    else if (wr_i)    status_q <= merge(status_q, wdata_i, STATUS_WMASK);
  end

  assign status_o = status_q;
endmodule

// File: rtl/exc_cause.sv
module exc_cause
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HW_W-1:0]   hw_irq_i,
  input  logic              take_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       cause_o
);
  logic [31:0] cause_q, cause_d;

  always_comb begin
    cause_d = cause_q;
    if (wr_i) cause_d = merge(cause_q, wdata_i, CAUSE_WMASK);
    if (take_i) cause_d[CODE_LSB +: CODE_W] = code_i;
    cause_d[HW_LSB +: HW_W] = hw_irq_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter logic [31:0]       VECTOR    = 32'h8000_0080,
  parameter logic [CODE_W-1:0] PRIV_CODE = 4'd11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  irq_i,
  input  logic        trap_req_i,
  input  logic [3:0]  trap_code_i,
  input  logic [31:0] pc_i,
  input  logic        eret_i,
  input  logic        reg_wr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        redirect_o,
  output logic [31:0] redirect_pc_o,
  output logic        kernel_o,
  output logic        ie_o
);
  logic [31:0]       status_q, cause_q, epc_q;
  logic              exc_take, take_trap, take_irq;
  logic [CODE_W-1:0] exc_code;
  logic              priv_fault, wr_ok, eret_ok;
  logic              status_wr, cause_wr, epc_wr;

  assign kernel_o   = !status_q[1];
  assign ie_o       = status_q[0];
  assign priv_fault = reg_wr_i && !kernel_o;
  assign eret_ok    = eret_i && !exc_take;
  assign wr_ok      = reg_wr_i && kernel_o && !exc_take && !eret_i;
  assign status_wr  = wr_ok && (reg_addr_i == 5'(REG_STATUS));
  assign cause_wr   = wr_ok && (reg_addr_i == 5'(REG_CAUSE));
  assign epc_wr     = wr_ok && (reg_addr_i == 5'(REG_EPC));

  exc_arbiter #(.PRIV_CODE(PRIV_CODE)) u_arb (
    .trap_req_i  (trap_req_i),
    .trap_code_i (trap_code_i),
    .priv_fault_i(priv_fault),
    .ie_i        (ie_o),
    .pend_i      (cause_q[SW_LSB +: PEND_W]),
    .mask_i      (status_q[MASK_LSB +: PEND_W]),
    .take_o      (exc_take),
    .take_trap_o (take_trap),
    .take_irq_o  (take_irq),
    .code_o      (exc_code)
  );

  exc_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (exc_take),
    .eret_i  (eret_ok),
    .wr_i    (status_wr),
    .wdata_i (reg_wdata_i),
    .status_o(status_q)
  );

  exc_cause u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_irq_i(irq_i),
    .take_i  (exc_take),
    .code_i  (exc_code),
    .wr_i    (cause_wr),
    .wdata_i (reg_wdata_i),
    .cause_o (cause_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        epc_q <= '0;
    else if (exc_take) epc_q <= pc_i;
    else if (epc_wr)   epc_q <= reg_wdata_i;
  end

  assign redirect_o    = exc_take || eret_i;
  assign redirect_pc_o = exc_take ? VECTOR : epc_q;

  always_comb begin
    case (reg_addr_i)
      5'(REG_STATUS): reg_rdata_o = status_q;
      5'(REG_CAUSE):  reg_rdata_o = cause_q;
      5'(REG_EPC):    reg_rdata_o = epc_q;
      default:        reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter logic [31:0] VECTOR    = 32'h8000_0080,
  parameter logic [3:0]  PRIV_CODE = 4'd11
) (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  irq_i,
  input logic        trap_req_i,
  input logic [3:0]  trap_code_i,
  input logic [31:0] pc_i,
  input logic        eret_i,
  input logic        reg_wr_i,
  input logic        kernel_o,
  input logic        ie_o,
  input logic        redirect_o,
  input logic [31:0] redirect_pc_o,
  input logic        exc_take,
  input logic        take_irq,
  input logic [31:0] status_q,
  input logic [31:0] cause_q,
  input logic [31:0] epc_q
);
  // R2
  entry_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> redirect_o && redirect_pc_o == VECTOR);
  // R2
  entry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> kernel_o && !ie_o && epc_q == $past(pc_i));
  // R2
  entry_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> status_q[5:2] == $past(status_q[3:0]));
  // R7
  return_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !exc_take) |=> status_q[3:0] == $past(status_q[5:2]) &&
                              status_q[5:4] == $past(status_q[5:4]));
  // R7
  return_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !exc_take) |-> redirect_o && redirect_pc_o == epc_q);
  // R5
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> ie_o);
  // R5
  irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> cause_q[5:2] == 4'd0);
  // R6
  trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_i |=> cause_q[5:2] == $past(trap_code_i));
  // R10
  trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_i |-> exc_take && !take_irq);
  // R9
  user_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !kernel_o && !trap_req_i) |=> cause_q[5:2] == PRIV_CODE);
  // R3
  hw_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cause_q[15:10] == $past(irq_i));
endmodule

bind exc_ctrl exc_ctrl_chk #(.VECTOR(VECTOR), .PRIV_CODE(PRIV_CODE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_i        (irq_i),
  .trap_req_i   (trap_req_i),
  .trap_code_i  (trap_code_i),
  .pc_i         (pc_i),
  .eret_i       (eret_i),
  .reg_wr_i     (reg_wr_i),
  .kernel_o     (kernel_o),
  .ie_o         (ie_o),
  .redirect_o   (redirect_o),
  .redirect_pc_o(redirect_pc_o),
  .exc_take     (exc_take),
  .take_irq     (take_irq),
  .status_q     (status_q),
  .cause_q      (cause_q),
  .epc_q        (epc_q)
);

// File: tb/exc_ctrl_tb.sv
module exc_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VEC = 32'h8000_0080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  irq_i = '0;
  logic        trap_req_i = 1'b0;
  logic [3:0]  trap_code_i = '0;
  logic [31:0] pc_i = '0;
  logic        eret_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o, redirect_pc_o;
  logic        redirect_o, kernel_o, ie_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_ctrl u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    trap_req_i = 1'b0; trap_code_i = '0; eret_i = 1'b0;
    reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
  endtask

  task automatic expect_redir(input logic [31:0] tgt, input string req);
    exp_q.push_back(tgt);
    tag_q.push_back(req);
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
    tick(); idle(); reg_addr_i = a;
    @(negedge clk);
    check(req, reg_rdata_o, exp);
  endtask

  task automatic mode(input logic k, input logic ie, input string req);
    tick(); idle();
    @(negedge clk);
    check(req, {30'd0, k, ie}, {30'd0, kernel_o, ie_o});
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    tick(); idle(); reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
  endtask

  task automatic trap(input logic [3:0] code, input logic [31:0] pc, input string req);
    tick(); idle(); trap_req_i = 1'b1; trap_code_i = code; pc_i = pc;
    expect_redir(VEC, req);
  endtask

  task automatic eret(input logic [31:0] tgt, input string req);
    tick(); idle(); eret_i = 1'b1;
    expect_redir(tgt, req);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && redirect_o) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2/R5 unexpected redirect act=%h exp=none", redirect_pc_o);
      end else begin
        automatic logic [31:0] t = exp_q.pop_front();
        automatic string s = tag_q.pop_front();
        check(s, redirect_pc_o, t);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 mode", {30'd0, kernel_o, ie_o}, 32'd2);
    rd(12, 32'h0, "R1 status");
    rd(13, 32'h0, "R1 cause");
    rd(14, 32'h0, "R1 epc");
    // R4 enter user mode with IE, mask hw line 0
    wr(12, 32'h0000_0403);
    mode(1'b0, 1'b1, "R4 user+ie");
    // R6 trap in user mode, R2 entry
    trap(4'd8, 32'h0000_1000, "R2 trap vector");
    mode(1'b1, 1'b0, "R2 kernel after trap");
    rd(12, 32'h0000_040C, "R2 status push");
    rd(13, 32'h0000_0020, "R6 trap code");
    rd(14, 32'h0000_1000, "R2 epc");
    // R7 return
    eret(32'h0000_1000, "R7 return target");
    rd(12, 32'h0000_0403, "R7 status pop");
    // R5 hardware interrupt
    tick(); idle(); irq_i = 6'b000001; pc_i = 32'h0000_2000;
    expect_redir(VEC, "R5 irq vector");
    tick();
    tick();
    @(negedge clk);
    check("R5 no irq while disabled", {31'd0, redirect_o}, 32'd0);
    rd(13, 32'h0000_0400, "R5 code0 and R3 hw pending");
    rd(14, 32'h0000_2000, "R5 epc");
    irq_i = '0;
    rd(13, 32'h0000_0000, "R3 pending tracks input");
    eret(32'h0000_2000, "R7 return from irq");
    rd(12, 32'h0000_0403, "R7 status after irq");
    // R9 user write faults
    tick(); idle(); reg_wr_i = 1'b1; reg_addr_i = 5'd12; reg_wdata_i = 32'h0; pc_i = 32'h0000_3000;
    expect_redir(VEC, "R9 user write traps");
    rd(12, 32'h0000_040C, "R9 status not written");
    rd(13, 32'h0000_002C, "R9 code 11");
    rd(14, 32'h0000_3000, "R9 epc");
    // R11 software interrupt, R3 hw bits read-only
    wr(13, 32'h0000_FD00);
    rd(13, 32'h0000_012C, "R11 sw bit set, R3 hw bits ignored");
    pc_i = 32'h0000_4000;
    wr(12, 32'h0000_0105);
    expect_redir(VEC, "R11 sw irq vector");
    rd(12, 32'h0000_0105, "R4 status written");
    rd(12, 32'h0000_0114, "R11 status push");
    rd(13, 32'h0000_0100, "R11 code 0");
    rd(14, 32'h0000_4000, "R11 epc");
    wr(13, 32'h0000_0000);
    eret(32'h0000_4000, "R7 return sw irq");
    rd(12, 32'h0000_0115, "R7 pop keeps oldest");
    // R10 trap beats pending interrupt
    wr(12, 32'h0000_0405);
    tick(); idle(); irq_i = 6'b000001;
    trap(4'd4, 32'h0000_5000, "R10 trap over irq");
    tick(); idle(); irq_i = '0;
    rd(13, 32'h0000_0010, "R10 trap code kept");
    rd(14, 32'h0000_5000, "R10 epc");
    rd(12, 32'h0000_0414, "R10 status push");
    // R10 exception beats return
    tick(); idle(); trap_req_i = 1'b1; trap_code_i = 4'd2; eret_i = 1'b1; pc_i = 32'h0000_6000;
    expect_redir(VEC, "R10 exception over eret");
    rd(12, 32'h0000_0410, "R10 push not pop");
    rd(14, 32'h0000_6000, "R10 epc on collision");
    // R8 unmapped register
    wr(5'd5, 32'hFFFF_FFFF);
    rd(5'd5, 32'h0, "R8 unmapped reads 0");
    rd(12, 32'h0000_0410, "R8 unmapped write no effect");
    tick(); idle();
    tick();
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2 missing redirects act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule